// File: doc/BRIEF.md
# Backlight Brightness Mode Controller

This block decides where the backlight brightness comes from and what the brightness register shows when it is read back. Two control bits choose one of three modes. In the first, a measured PWM duty sets the brightness directly. In the second, the value stored over the serial bus sets it. In the third, the stored value is scaled by the measured duty, which is how a host trims panel power without rewriting the register. The block produces an 8-bit effective brightness for the dimming stage. It also produces a backlight-on status that rises after a programmable delay once the on bit is set, and drops at once when that bit is cleared.

The bus side of the block supplies a one-cycle write strobe with a data byte aimed at the brightness register, plus the three control bits held at their latched values. The duty input is an 8-bit fraction that arrives already measured. The block never changes the light level by itself when moving between modes. On entry to either bus mode it holds the level that was in effect until software writes a new brightness.

Top module: `bl_mode_ctrl`

## Requirements
- R1: With `pwm_sel` = 1 the block is in duty mode whatever `pwm_md` is, and `bri_out` equals the `duty` input sampled at the previous clock edge.
- R2: With `pwm_sel` = 0 and `pwm_md` = 1 (direct bus mode), and no hold pending, `bri_out` equals the stored brightness, one edge after a write.
- R3: With `pwm_sel` = 0 and `pwm_md` = 0 (scaled mode), and no hold pending, `bri_out` is registered one edge later as (stored × e + 127) >> 8. Here e = duty + duty[7], so duty 0xFF stands for 100 % and returns the stored value unchanged, and duty 0x00 gives 0.
- R4: While reset is active, the stored brightness and `bri_out` are 0xFF, `bri_rd` is 0xFF and `bl_on` is 0.
- R5: `bri_rd` returns the last accepted bus write while the mode registered at the last edge is a bus mode, and returns `bri_out` while that mode is duty mode.
- R6: A `bri_wr` strobe sampled while `pwm_sel` = 1 leaves the stored brightness unchanged.
- R7: A change into a bus mode from any other mode, with no accepted write in that cycle, freezes `bri_out` at its current value. Duty changes are then ignored until the next accepted write, which ends the hold. A write in the same cycle as the mode change takes effect and no hold starts.
- R8: `bl_on` rises exactly `ON_DLY` clock edges after the first edge that samples `bl_ctl` = 1, provided `bl_ctl` stays high throughout.
- R9: `bl_on` is 0 in the same cycle that `bl_ctl` is 0, with no clock edge needed. A later rise of `bl_ctl` restarts the full delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bri_wr | input | 1 | One-cycle write strobe for the brightness register |
| bri_wdata | input | 8 | Brightness byte carried by the write |
| pwm_md | input | 1 | 1 = direct bus mode, 0 = scaled mode (used only when `pwm_sel` = 0) |
| pwm_sel | input | 1 | 1 = brightness taken from the duty input |
| bl_ctl | input | 1 | Backlight on request |
| duty | input | 8 | Measured PWM duty, 0xFF = 100 % |
| bri_out | output | 8 | Effective brightness for the dimming stage |
| bl_on | output | 1 | Backlight-on status and dimming enable |
| bri_rd | output | 8 | Value returned by a brightness register read |

## Verification
A brightness write and a change into a bus mode can land on the same clock edge. That edge decides whether the level is frozen or replaced by the written value. The bench provokes this with a directed step that leaves duty mode and writes a new value in one cycle. Random stimulus also changes the mode bits and issues writes freely, so the two coincide many times. Each such edge is judged against a reference model where the write wins, with `bri_out` and `bri_rd` compared one edge later.

// File: rtl/bl_pkg.sv
package bl_pkg;

    typedef enum logic [1:0] {
        MODE_SCALED = 2'd0,
        MODE_DIRECT = 2'd1,
        MODE_DUTY   = 2'd2
    } bl_mode_e;

endpackage

// File: rtl/bl_mode_decode.sv
module bl_mode_decode
    import bl_pkg::*;
(
    input  logic     pwm_sel,
    input  logic     pwm_md,
    input  bl_mode_e mode_q,
    output bl_mode_e mode_now,
    output logic     bus_mode,
    output logic     enter_bus
);

    always_comb begin
        if (pwm_sel) begin
            mode_now = MODE_DUTY;
        end else if (pwm_md) begin
            mode_now = MODE_DIRECT;
        end else begin
            mode_now = MODE_SCALED;
        end
        bus_mode  = (mode_now != MODE_DUTY);
        enter_bus = bus_mode && (mode_now != mode_q);
    end

endmodule

// File: rtl/bl_duty_scaler.sv
module bl_duty_scaler #(
    parameter int BRI_W = 8
) (
    input  logic [BRI_W-1:0] level,
    input  logic [BRI_W-1:0] duty,
    output logic [BRI_W-1:0] scaled
);

    localparam int PW  = 2 * BRI_W;
    localparam int RND = (2 ** (BRI_W - 1)) - 1;

    logic [BRI_W:0]   duty_eff;
    logic [PW-1:0]    prod;
    logic             unused_low;

    always_comb begin
        // full-scale duty maps to 2^BRI_W so that 100 % is exact
        duty_eff = {1'b0, duty} + {{BRI_W{1'b0}}, duty[BRI_W-1]};
        prod     = PW'(level) * PW'(duty_eff) + PW'(RND);
        scaled   = prod[PW-1:BRI_W];
    end

    assign unused_low = ^prod[BRI_W-1:0];

endmodule

// File: rtl/bl_on_timer.sv
module bl_on_timer #(
    parameter int ON_DLY = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bl_ctl,
    output logic bl_on
);

    localparam int CW = (ON_DLY > 1) ? $clog2(ON_DLY) : 1;
    localparam logic [CW-1:0] LAST = CW'(ON_DLY - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          on;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!bl_ctl) begin
            tmr_d.cnt = '0;
            tmr_d.on  = 1'b0;
        end else if (!tmr_q.on) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.cnt = '0;
                tmr_d.on  = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // off path bypasses the register so the light drops immediately
    assign bl_on = tmr_q.on & bl_ctl;

endmodule

// File: rtl/bl_mode_ctrl.sv
module bl_mode_ctrl
    import bl_pkg::*;
#(
    parameter int BRI_W  = 8,
    parameter int ON_DLY = 1250000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bri_wr,
    input  logic [BRI_W-1:0] bri_wdata,
    input  logic             pwm_md,
    input  logic             pwm_sel,
    input  logic             bl_ctl,
    input  logic [BRI_W-1:0] duty,
    output logic [BRI_W-1:0] bri_out,
    output logic             bl_on,
    output logic [BRI_W-1:0] bri_rd
);

    localparam logic [BRI_W-1:0] BRI_MAX = '1;

    typedef struct packed {
        logic [BRI_W-1:0] stored;
        logic [BRI_W-1:0] level;
        logic             hold;
        bl_mode_e         mode;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    bl_mode_e         mode_now;
    logic             bus_mode;
    logic             enter_bus;
    logic             wr_ok;
    logic [BRI_W-1:0] scaled;

    bl_mode_decode u_decode (
        .pwm_sel   (pwm_sel),
        .pwm_md    (pwm_md),
        .mode_q    (ctl_q.mode),
        .mode_now  (mode_now),
        .bus_mode  (bus_mode),
        .enter_bus (enter_bus)
    );

    assign wr_ok = bri_wr && bus_mode;

    bl_duty_scaler #(.BRI_W(BRI_W)) u_scaler (
        .level  (ctl_d.stored),
        .duty   (duty),
        .scaled (scaled)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.mode = mode_now;

        if (wr_ok) begin
            ctl_d.stored = bri_wdata;
        end

        if (wr_ok) begin
            ctl_d.hold = 1'b0;
        end else if (enter_bus) begin
            ctl_d.hold = 1'b1;
        end else if (!bus_mode) begin
            ctl_d.hold = 1'b0;
        end

        unique case (mode_now)
            MODE_DUTY:   ctl_d.level = duty;
            MODE_DIRECT: ctl_d.level = ctl_d.hold ? ctl_q.level : ctl_d.stored;
            default:     ctl_d.level = ctl_d.hold ? ctl_q.level : scaled;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.stored <= BRI_MAX;
            ctl_q.level  <= BRI_MAX;
            ctl_q.hold   <= 1'b0;
            ctl_q.mode   <= MODE_SCALED;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bl_on_timer #(.ON_DLY(ON_DLY)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .bl_ctl (bl_ctl),
        .bl_on  (bl_on)
    );

    assign bri_out = ctl_q.level;
    assign bri_rd  = (ctl_q.mode == MODE_DUTY) ? ctl_q.level : ctl_q.stored;

endmodule

// File: rtl/bl_mode_ctrl_chk.sv
module bl_mode_ctrl_chk #(
    parameter int BRI_W  = 8,
    parameter int ON_DLY = 1250000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bri_wr,
    input logic [BRI_W-1:0] bri_wdata,
    input logic             pwm_sel,
    input logic             bl_ctl,
    input logic [BRI_W-1:0] duty,
    input logic [BRI_W-1:0] bri_out,
    input logic             bl_on,
    input logic [BRI_W-1:0] bri_rd
);

    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!bl_ctl) begin
            run_q <= '0;
        end else if (run_q != '1) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R1
    duty_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_sel |=> (bri_out == $past(duty)));

    // R5
    rd_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwm_sel) |-> (bri_rd == bri_out));

    // R5
    rd_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_sel && bri_wr) |=> (bri_rd == $past(bri_wdata)));

    // R7
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwm_sel) && !pwm_sel && !bri_wr) |=> $stable(bri_out));

    // R8
    on_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bl_on) |-> (run_q == 32'(ON_DLY)));

    // R9
    off_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bl_ctl |-> !bl_on);

endmodule

bind bl_mode_ctrl bl_mode_ctrl_chk #(.BRI_W(BRI_W), .ON_DLY(ON_DLY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bri_wr    (bri_wr),
    .bri_wdata (bri_wdata),
    .pwm_sel   (pwm_sel),
    .bl_ctl    (bl_ctl),
    .duty      (duty),
    .bri_out   (bri_out),
    .bl_on     (bl_on),
    .bri_rd    (bri_rd)
);

// File: tb/test_bl_mode_ctrl.sv
module test_bl_mode_ctrl;

    localparam int DLY = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bri_wr = 1'b0;
    logic [7:0] bri_wdata = 8'h00;
    logic       pwm_md = 1'b0;
    logic       pwm_sel = 1'b0;
    logic       bl_ctl = 1'b0;
    logic [7:0] duty = 8'hFF;
    logic [7:0] bri_out;
    logic       bl_on;
    logic [7:0] bri_rd;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] m_stored = 8'hFF;
    logic [7:0] m_lvl = 8'hFF;
    bit         m_hold = 1'b0;
    int         m_mode = 0;   // 0 scaled, 1 direct, 2 duty
    int         m_cnt = 0;
    bit         m_on = 1'b0;
    string      m_tag = "R4";

    always #4 clk = ~clk;

    bl_mode_ctrl #(.BRI_W(8), .ON_DLY(DLY)) i_bl_mode_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bri_wr    (bri_wr),
        .bri_wdata (bri_wdata),
        .pwm_md    (pwm_md),
        .pwm_sel   (pwm_sel),
        .bl_ctl    (bl_ctl),
        .duty      (duty),
        .bri_out   (bri_out),
        .bl_on     (bl_on),
        .bri_rd    (bri_rd)
    );

    function automatic logic [7:0] scale_ref(input logic [7:0] s, input logic [7:0] d);
        int e;
        e = int'(d) + int'(d[7]);
        return 8'((int'(s) * e + 127) >> 8);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        int         mn;
        bit         acc, ent, nh;
        logic [7:0] ns, nl;
        mn  = pwm_sel ? 2 : (pwm_md ? 1 : 0);
        acc = bri_wr && (mn != 2);
        ent = (mn != 2) && (mn != m_mode);
        ns  = acc ? bri_wdata : m_stored;
        if (acc) nh = 1'b0;
        else if (ent) nh = 1'b1;
        else if (mn == 2) nh = 1'b0;
        else nh = m_hold;
        if (mn == 2) begin nl = duty; m_tag = "R1"; end
        else if (nh) begin nl = m_lvl; m_tag = "R7"; end
        else if (mn == 1) begin nl = ns; m_tag = "R2"; end
        else begin nl = scale_ref(ns, duty); m_tag = "R3"; end
        if (!bl_ctl) begin m_cnt = 0; m_on = 1'b0; end
        else if (!m_on) begin
            if (m_cnt == DLY - 1) begin m_cnt = 0; m_on = 1'b1; end
            else m_cnt++;
        end
        @(posedge clk);
        #2;
        m_stored = ns; m_lvl = nl; m_hold = nh; m_mode = mn;
        bri_wr = 1'b0;
        check(m_tag, bri_out, nl);
        check("R5", bri_rd, (mn == 2) ? nl : ns);
        check(bl_ctl ? "R8" : "R9", bl_on, m_on & bl_ctl);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int rise;
        #20;
        // R4 reset values
        check("R4", bri_out, 8'hFF);
        check("R4", bri_rd, 8'hFF);
        check("R4", bl_on, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        step();

        // R3 scaled mode corners
        bri_wr = 1'b1; bri_wdata = 8'h80; duty = 8'hFF; step();
        check("R3", bri_out, 8'h80);
        duty = 8'h00; step();
        check("R3", bri_out, 8'h00);
        duty = 8'h80; step();
        check("R3", bri_out, 8'h40);

        // R7 entering direct mode holds, then R2 write applies
        pwm_md = 1'b1; step();
        check("R7", bri_out, 8'h40);
        bri_wr = 1'b1; bri_wdata = 8'h33; step();
        check("R2", bri_out, 8'h33);

        // R1 duty mode, R6 write ignored
        pwm_sel = 1'b1; duty = 8'h5A; step();
        check("R1", bri_out, 8'h5A);
        bri_wr = 1'b1; bri_wdata = 8'h11; step();
        check("R5", bri_rd, 8'h5A);
        pwm_sel = 1'b0; step();
        check("R6", bri_rd, 8'h33);
        check("R7", bri_out, 8'h5A);

        // R7 write in the same cycle as entry wins
        pwm_sel = 1'b1; duty = 8'h21; step();
        pwm_sel = 1'b0; pwm_md = 1'b0; duty = 8'hFF;
        bri_wr = 1'b1; bri_wdata = 8'h77; step();
        check("R7", bri_out, 8'h77);

        // R8 on delay
        bl_ctl = 1'b1; rise = 0;
        for (int k = 1; k <= DLY + 3; k++) begin
            step();
            if (bl_on && rise == 0) rise = k;
        end
        check("R8", rise, DLY);

        // R9 immediate off, no edge
        bl_ctl = 1'b0;
        #1;
        check("R9", bl_on, 0);
        step();
        bl_ctl = 1'b1; step(); step();
        check("R9", bl_on, 0);

        // random phase
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 5 == 0) begin
                pwm_sel = $urandom % 3 == 0;
                pwm_md  = $urandom % 2;
            end
            if ($urandom % 3 == 0) begin
                bri_wr = 1'b1;
                case ($urandom % 4)
                    0: bri_wdata = 8'h00;
                    1: bri_wdata = 8'hFF;
                    default: bri_wdata = 8'($urandom);
                endcase
            end
            if ($urandom % 2 == 0) begin
                case ($urandom % 4)
                    0: duty = 8'h00;
                    1: duty = 8'hFF;
                    default: duty = 8'($urandom);
                endcase
            end
            if ($urandom % 40 == 0) bl_ctl = ~bl_ctl;
            step();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule